// File: doc/BRIEF.md
# Serial ADC Host Controller

This block drives a 12-bit serial sampling converter from a fast system clock. It produces the converter's active-low convert strobe and a gated serial clock, and it collects the returned serial bits into a parallel result that is announced with a one-cycle valid pulse. A conversion is triggered either by a start pulse or by a programmable rate timer. The strobe is held high for a programmable acquisition time before it falls to sample the input.

The converter picks its readout behaviour from where the strobe sits relative to the serial clock count. The controller offers four transfer modes by placing the strobe edges at the right serial clock rising edges: a normal transfer, a transfer that leaves the converter powered down between samples, a transfer that reads the result a second time in LSB-first order, and a short-cycled transfer that stops after a programmable number of bits. The serial clock half period comes from a divider input, clamped so that the generated clock always meets the converter's minimum and maximum clock timing for the configured system clock period.

Top module: `adc_serial_host`

## Requirements
- R1: After reset conv_o is 1, sclk_o is 0, valid_o is 0, result_o is 0, overrun_o is 0, and busy_o is 1 until the first acquisition time has elapsed.
- R2: Every serial clock high and low phase lasts H system cycles, where H is clk_div_i clamped to the range [4, 125] for the default 20 ns system clock (62.5 ns minimum half period, 2.5 us maximum).
- R3: conv_o stays high for at least L system cycles before it falls to start a conversion, with L equal to acq_len_i raised to a minimum of 18 (350 ns); busy_o is 0 only when no transfer runs and that time has elapsed.
- R4: A trigger seen while busy_o is 0 makes conv_o fall and busy_o rise on the next clock edge, with sclk_o still low; the first sclk_o rising edge follows H cycles later.
- R5: Within a transfer conv_o changes only on the system clock edge where sclk_o rises, never where it falls; after a transfer that ends with conv_o low, conv_o rises one cycle after valid_o.
- R6: The bit on sdata_i is captured at each sclk_o rising edge; period 1 is ignored and periods 2 to 13 carry result bits 11 down to 0. In normal mode (mode_i = 0) conv_o rises at the period-1 rising edge, the transfer lasts 13 periods, and result_o is loaded together with a single-cycle valid_o pulse.
- R7: In power-down mode (mode_i = 1) conv_o stays low for all 13 periods and through the valid_o cycle.
- R8: In LSB-first mode (mode_i = 2) conv_o rises at the period-1 rising edge and falls at the period-13 rising edge; 11 more periods follow, periods 14 to 24 carrying bits 1 to 11, and result_o is assembled from bit 0 plus those bits.
- R9: In short-cycle mode (mode_i = 3) with N equal to short_bits_i clamped to [1, 11], conv_o falls at the rising edge of period N+1 after that bit is captured, the transfer ends after period N+1, and result_o holds the N received bits at the top with all lower bits zero.
- R10: With rate_en_i set, a trigger is generated every P system cycles, P being rate_period_i (0 treated as 1), the first one P cycles after enabling.
- R11: A trigger arriving while busy_o is 1 starts nothing and sets overrun_o, which stays set until reset.
- R12: Mode, bit count and divider are taken when a conversion is accepted; changing them during a transfer does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request pulse |
| rate_en_i | input | 1 | Enables the periodic trigger timer |
| rate_period_i | input | RATE_W | Trigger period in system cycles |
| clk_div_i | input | DIV_W | Requested serial clock half period in system cycles |
| acq_len_i | input | ACQ_W | Requested acquisition time in system cycles |
| mode_i | input | 2 | Transfer mode: 0 normal, 1 power-down, 2 LSB-first, 3 short-cycle |
| short_bits_i | input | 4 | Bits to read in short-cycle mode |
| sdata_i | input | 1 | Serial data from the converter |
| conv_o | output | 1 | Convert strobe to the converter, falling edge samples |
| sclk_o | output | 1 | Gated serial clock to the converter |
| busy_o | output | 1 | Transfer running or acquisition time not yet met |
| valid_o | output | 1 | One-cycle pulse when result_o is updated |
| result_o | output | 12 | Last conversion result |
| overrun_o | output | 1 | Sticky flag: a trigger arrived while busy |

## Verification
A wrong period count or phase counter in the sequencer shows at once as an sclk_o edge one or more system cycles early or late, or as a conv_o edge at the wrong serial period, which the cycle-accurate model catches on that very cycle. A wrong bit index or mode latch leaves the strobe and clock correct but corrupts result_o, visible only at the valid_o pulse closing the transfer, up to 24 serial periods later. An acquisition or rate counter off by one moves the next conv_o fall or busy_o drop by a cycle and is flagged at that cycle.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_SLEEP  = 2'd1,
    MODE_LSB    = 2'd2,
    MODE_SHORT  = 2'd3
  } xfer_mode_e;

  localparam int unsigned RES_W     = 12;
  localparam int unsigned PER_W     = 5;
  localparam int unsigned MSB_LAST  = RES_W + 1;
  localparam int unsigned LSB_LAST  = 2 * RES_W;
  localparam int unsigned SHORT_MAX = RES_W - 1;

  function automatic int unsigned ceil_div(int unsigned a, int unsigned b);
    return (a + b - 1) / b;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned min_u(int unsigned a, int unsigned b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_rate_timer.sv
module adc_rate_timer #(
  parameter int unsigned RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [RATE_W-1:0] period_i,
  output logic              tick_o
);

  logic [RATE_W-1:0] cnt_q;
  logic [RATE_W-1:0] last_cnt;

  assign last_cnt = (period_i == '0) ? '0 : period_i - 1'b1;
  assign tick_o   = en_i && (cnt_q >= last_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/adc_acq_timer.sv
module adc_acq_timer #(
  parameter int unsigned ACQ_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_i,
  input  logic [ACQ_W-1:0] len_i,
  output logic             done_o
);

  localparam logic [ACQ_W-1:0] CNT_MAX = '1;

  logic [ACQ_W-1:0] cnt_q;

  assign done_o = (cnt_q >= len_i);

  // counts cycles with the strobe high; saturates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!conv_i)         cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/adc_xfer_seq.sv
module adc_xfer_seq
  import adc_host_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             acq_done_i,
  input  logic [DIV_W-1:0] half_i,
  input  xfer_mode_e       mode_i,
  input  logic [3:0]       nbits_i,
  input  logic             sdata_i,
  output logic             conv_o,
  output logic             sclk_o,
  output logic             busy_o,
  output logic             valid_o,
  output logic [RES_W-1:0] result_o,
  output logic             overrun_o
);

  localparam logic [PER_W-1:0] PER_ONE  = PER_W'(1);
  localparam logic [PER_W-1:0] PER_TWO  = PER_W'(2);
  localparam logic [PER_W-1:0] PER_MSB  = PER_W'(MSB_LAST);
  localparam logic [PER_W-1:0] PER_LSB  = PER_W'(LSB_LAST);

  logic             xfer_q, hi_q;
  logic [DIV_W-1:0] ph_cnt_q, half_q;
  logic [PER_W-1:0] per_q, last_q, drop_q;
  xfer_mode_e       mode_q;
  logic [RES_W-1:0] shift_q;

  logic             accept, phase_end, rise_ev, fall_ev;
  logic [PER_W-1:0] bit_idx, last_d, drop_d;

  assign busy_o    = xfer_q || !acq_done_i;
  assign accept    = trig_i && !busy_o;
  assign phase_end = xfer_q && (ph_cnt_q == half_q - 1'b1);
  assign rise_ev   = phase_end && !hi_q;
  assign fall_ev   = phase_end && hi_q;
  assign bit_idx   = (per_q <= PER_MSB) ? PER_MSB - per_q : per_q - PER_MSB;

  // period count and strobe-drop period chosen at acceptance
  always_comb begin
    last_d = PER_MSB;
    drop_d = '0;
    unique case (mode_i)
      MODE_LSB: begin
        last_d = PER_LSB;
        drop_d = PER_MSB;
      end
      MODE_SHORT: begin
        last_d = PER_W'(nbits_i) + PER_ONE;
        drop_d = PER_W'(nbits_i) + PER_ONE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xfer_q    <= 1'b0;
      hi_q      <= 1'b0;
      ph_cnt_q  <= '0;
      half_q    <= '0;
      per_q     <= '0;
      last_q    <= '0;
      drop_q    <= '0;
      mode_q    <= MODE_NORMAL;
      shift_q   <= '0;
      conv_o    <= 1'b1;
      sclk_o    <= 1'b0;
      valid_o   <= 1'b0;
      result_o  <= '0;
      overrun_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (trig_i && busy_o) overrun_o <= 1'b1;

      if (accept) begin
        xfer_q   <= 1'b1;
        hi_q     <= 1'b0;
        ph_cnt_q <= '0;
        half_q   <= half_i;
        per_q    <= PER_ONE;
        last_q   <= last_d;
        drop_q   <= drop_d;
        mode_q   <= mode_i;
        shift_q  <= '0;
        conv_o   <= 1'b0;
      end else if (!xfer_q) begin
        conv_o <= 1'b1;
      end else if (rise_ev) begin
        sclk_o   <= 1'b1;
        hi_q     <= 1'b1;
        ph_cnt_q <= '0;
        if (per_q >= PER_TWO) shift_q[bit_idx[3:0]] <= sdata_i;
        if (per_q == PER_ONE && mode_q != MODE_SLEEP) conv_o <= 1'b1;
        else if (drop_q != '0 && per_q == drop_q)     conv_o <= 1'b0;
      end else if (fall_ev) begin
        sclk_o   <= 1'b0;
        hi_q     <= 1'b0;
        ph_cnt_q <= '0;
        if (per_q == last_q) begin
          xfer_q   <= 1'b0;
          valid_o  <= 1'b1;
          result_o <= shift_q;
        end else begin
          per_q <= per_q + PER_ONE;
        end
      end else begin
        ph_cnt_q <= ph_cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host
  import adc_host_pkg::*;
#(
  parameter int unsigned SYS_CLK_NS = 20,
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned ACQ_W      = 8,
  parameter int unsigned RATE_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rate_en_i,
  input  logic [RATE_W-1:0] rate_period_i,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic [ACQ_W-1:0]  acq_len_i,
  input  logic [1:0]        mode_i,
  input  logic [3:0]        short_bits_i,
  input  logic              sdata_i,
  output logic              conv_o,
  output logic              sclk_o,
  output logic              busy_o,
  output logic              valid_o,
  output logic [11:0]       result_o,
  output logic              overrun_o
);

  // serial clock: half >= 50 ns, period >= 125 ns, period <= 5 us
  localparam int unsigned MIN_HALF = max_u(ceil_div(50, SYS_CLK_NS), ceil_div(125, 2 * SYS_CLK_NS));
  localparam int unsigned MAX_HALF = min_u(2500 / SYS_CLK_NS, (1 << DIV_W) - 1);
  localparam int unsigned MIN_ACQ  = min_u(ceil_div(350, SYS_CLK_NS), (1 << ACQ_W) - 1);

  localparam logic [DIV_W-1:0] HALF_LO = DIV_W'(MIN_HALF);
  localparam logic [DIV_W-1:0] HALF_HI = DIV_W'(MAX_HALF);
  localparam logic [ACQ_W-1:0] ACQ_LO  = ACQ_W'(MIN_ACQ);
  localparam logic [3:0]       BITS_HI = 4'(SHORT_MAX);

  logic [DIV_W-1:0] half_eff;
  logic [ACQ_W-1:0] acq_eff;
  logic [3:0]       nbits_eff;
  logic             rate_tick, trig, acq_done;

  assign half_eff  = (clk_div_i < HALF_LO) ? HALF_LO :
                     (clk_div_i > HALF_HI) ? HALF_HI : clk_div_i;
  assign acq_eff   = (acq_len_i < ACQ_LO) ? ACQ_LO : acq_len_i;
  assign nbits_eff = (short_bits_i == 4'd0)    ? 4'd1 :
                     (short_bits_i > BITS_HI)  ? BITS_HI : short_bits_i;
  assign trig      = start_i || rate_tick;

  adc_rate_timer #(.RATE_W(RATE_W)) u_rate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (rate_en_i),
    .period_i (rate_period_i),
    .tick_o   (rate_tick)
  );

  adc_acq_timer #(.ACQ_W(ACQ_W)) u_acq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .conv_i (conv_o),
    .len_i  (acq_eff),
    .done_o (acq_done)
  );

  adc_xfer_seq #(.DIV_W(DIV_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig),
    .acq_done_i (acq_done),
    .half_i     (half_eff),
    .mode_i     (xfer_mode_e'(mode_i)),
    .nbits_i    (nbits_eff),
    .sdata_i    (sdata_i),
    .conv_o     (conv_o),
    .sclk_o     (sclk_o),
    .busy_o     (busy_o),
    .valid_o    (valid_o),
    .result_o   (result_o),
    .overrun_o  (overrun_o)
  );

endmodule

// File: rtl/adc_host_chk.sv
module adc_host_chk #(
  parameter int unsigned MIN_HALF = 4,
  parameter int unsigned MIN_ACQ  = 18
) (
  input logic clk_i,
  input logic rst_ni,
  input logic conv_i,
  input logic sclk_i,
  input logic busy_i,
  input logic valid_i,
  input logic overrun_i
);

  logic        sclk_d;
  logic [15:0] run_cnt, hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d  <= 1'b0;
      run_cnt <= '0;
      hi_cnt  <= '0;
    end else begin
      sclk_d  <= sclk_i;
      run_cnt <= (sclk_i != sclk_d) ? 16'd1 : ((run_cnt != '1) ? run_cnt + 16'd1 : run_cnt);
      hi_cnt  <= !conv_i ? 16'd0 : ((hi_cnt != '1) ? hi_cnt + 16'd1 : hi_cnt);
    end
  end

  // R2
  half_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sclk_i) || $fell(sclk_i)) |-> (run_cnt >= 16'(MIN_HALF)));

  // R3
  acq_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> ($fell(conv_i) && $past(hi_cnt) >= 16'(MIN_ACQ)));

  // R5
  conv_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(conv_i) |-> !$fell(sclk_i));

  // R4
  sclk_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_i |-> busy_i);

  // R6
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  // R11
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_i |=> overrun_i);

endmodule

bind adc_serial_host adc_host_chk #(
  .MIN_HALF(MIN_HALF),
  .MIN_ACQ (MIN_ACQ)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .conv_i    (conv_o),
  .sclk_i    (sclk_o),
  .busy_i    (busy_o),
  .valid_i   (valid_o),
  .overrun_i (overrun_o)
);

// File: tb/adc_serial_host_tb.sv
module adc_serial_host_tb;

  localparam int H_MIN = 4, H_MAX = 125, ACQ_MIN = 18;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0, rate_en_i = 1'b0, sdata_i = 1'b1;
  logic [15:0] rate_period_i = 16'd300;
  logic [7:0]  clk_div_i = 8'd4, acq_len_i = 8'd0;
  logic [1:0]  mode_i = 2'd0;
  logic [3:0]  short_bits_i = 4'd4;
  logic        conv_o, sclk_o, busy_o, valid_o, overrun_o;
  logic [11:0] result_o;

  always #10 clk_i = ~clk_i;

  adc_serial_host u_dut (
    .clk_i, .rst_ni, .start_i, .rate_en_i, .rate_period_i, .clk_div_i,
    .acq_len_i, .mode_i, .short_bits_i, .sdata_i,
    .conv_o, .sclk_o, .busy_o, .valid_o, .result_o, .overrun_o
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit fin = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  // ---------------- converter model ----------------
  logic [11:0] adc_data = 12'h000;
  bit a_act, a_raised, a_lsb, c_prev, s_prev;
  int a_fc;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_act = 0; a_raised = 0; a_lsb = 0; a_fc = 0; sdata_i = 1'b1;
      c_prev = 1; s_prev = 0;
    end else begin
      if (c_prev && !conv_o) begin
        if (a_act && a_raised && a_fc == 12) a_lsb = 1;
        else if (a_act && a_raised && a_fc < 12) begin a_act = 0; sdata_i = 1'b1; end
        else begin a_act = 1; a_fc = 0; a_raised = 0; a_lsb = 0; sdata_i = 1'b0; end
      end
      if (!c_prev && conv_o) a_raised = 1;
      if (s_prev && !sclk_o && a_act) begin
        a_fc++;
        if (a_fc <= 12) sdata_i = adc_data[12-a_fc];
        else if (a_lsb && a_fc <= 23) sdata_i = adc_data[a_fc-12];
        else sdata_i = 1'b0;
      end
      c_prev = conv_o; s_prev = sclk_o;
    end
  end

  // ---------------- reference model ----------------
  typedef struct packed { logic conv; logic sclk; logic valid; logic xfer; } ent_t;
  localparam ent_t IDLE_E = '{conv: 1'b1, sclk: 1'b0, valid: 1'b0, xfer: 1'b0};
  ent_t q[$];
  ent_t cur = IDLE_E;
  int hi_cnt = 0, rc = 0;
  bit m_ovr = 0;
  logic [11:0] m_res = '0, m_pend = '0;

  function automatic int acq_l();
    return (acq_len_i < ACQ_MIN) ? ACQ_MIN : int'(acq_len_i);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    int h, lp, nn, pp;
    bit tick, trig, bsy;
    logic c;
    if (!rst_ni) begin
      q.delete(); cur = IDLE_E; hi_cnt = 0; rc = 0; m_ovr = 0; m_res = '0;
    end else begin
      bsy  = cur.xfer || hi_cnt < acq_l();
      tick = 0;
      if (!rate_en_i) rc = 0;
      else begin
        pp = (rate_period_i == 0) ? 1 : int'(rate_period_i);
        rc++;
        if (rc >= pp) begin tick = 1; rc = 0; end
      end
      trig = start_i || tick;
      if (trig && bsy) m_ovr = 1;
      hi_cnt = cur.conv ? hi_cnt + 1 : 0;
      if (trig && !bsy) begin
        h  = clampi(int'(clk_div_i), H_MIN, H_MAX);
        nn = clampi(int'(short_bits_i), 1, 11);
        lp = (mode_i == 2) ? 24 : (mode_i == 3) ? nn + 1 : 13;
        c  = 1'b0;
        for (int p = 1; p <= lp; p++) begin
          repeat (h) q.push_back('{conv: c, sclk: 1'b0, valid: 1'b0, xfer: 1'b1});
          if (mode_i != 1 && p == 1) c = 1'b1;
          if (mode_i == 2 && p == 13) c = 1'b0;
          if (mode_i == 3 && p == nn + 1) c = 1'b0;
          repeat (h) q.push_back('{conv: c, sclk: 1'b1, valid: 1'b0, xfer: 1'b1});
        end
        q.push_back('{conv: c, sclk: 1'b0, valid: 1'b1, xfer: 1'b0});
        m_pend = (mode_i == 3) ? (adc_data & ~((12'h1 << (12 - nn)) - 12'h1)) : adc_data;
      end
      cur = (q.size() > 0) ? q.pop_front() : IDLE_E;
      if (cur.valid) m_res = m_pend;
    end
  end

  bit cmp_en = 0;
  always @(negedge clk_i) begin
    if (rst_ni && cmp_en && !fin) begin
      chk(conv_o == cur.conv,   "R5 conv_o",    conv_o,    cur.conv);
      chk(sclk_o == cur.sclk,   "R2 sclk_o",    sclk_o,    cur.sclk);
      chk(valid_o == cur.valid, "R6 valid_o",   valid_o,   cur.valid);
      chk(busy_o == (cur.xfer || hi_cnt < acq_l()), "R3 busy_o", busy_o, cur.xfer || hi_cnt < acq_l());
      chk(overrun_o == m_ovr,   "R11 overrun_o", overrun_o, m_ovr);
      chk(result_o == m_res,    "R6 result_o",  result_o,  m_res);
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !fin) begin
      fin = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- directed stimulus ----------------
  int falls, hi_seen;

  task automatic wait_ready();
    int lim = 0;
    while (busy_o && lim < 5000) begin @(negedge clk_i); lim++; end
  endtask

  task automatic do_conv(input logic [1:0] md, input logic [7:0] dv, input logic [3:0] nb,
                         input logic [11:0] d, input logic [11:0] exp, input string req);
    int cnt = 0, lim = 0;
    bit pc;
    wait_ready();
    mode_i = md; clk_div_i = dv; short_bits_i = nb; adc_data = d;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    // R4: strobe low, busy high right after acceptance
    chk(conv_o == 1'b0 && busy_o && !sclk_o, "R4 accept", {conv_o, busy_o, sclk_o}, 3'b010);
    while (!sclk_o && cnt < 300) begin cnt++; @(negedge clk_i); end
    chk(cnt == clampi(int'(dv), H_MIN, H_MAX), "R2 first half", cnt, clampi(int'(dv), H_MIN, H_MAX));
    falls = 0; hi_seen = 0; pc = conv_o;
    while (!valid_o && lim < 8000) begin
      @(negedge clk_i); lim++;
      if (pc && !conv_o) falls++;
      if (conv_o) hi_seen++;
      pc = conv_o;
    end
    chk(result_o == exp, req, result_o, exp);
  endtask

  initial begin
    int cnt, nv;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk(conv_o && !sclk_o && !valid_o && !overrun_o && result_o == 0, "R1 reset",
        {conv_o, sclk_o, valid_o, overrun_o, result_o}, 16'h8000);
    chk(busy_o == 1'b1, "R1 busy", busy_o, 1);
    cmp_en = 1;

    // R6 normal mode, divider below minimum
    do_conv(2'd0, 8'd1, 4'd4, 12'hA5C, 12'hA5C, "R6 normal");
    chk(falls == 0, "R6 strobe stays high", falls, 0);
    do_conv(2'd0, 8'd6, 4'd4, 12'h001, 12'h001, "R6 normal lsb only");
    do_conv(2'd0, 8'd200, 4'd4, 12'hFFF, 12'hFFF, "R2 max clamp");

    // R7 power-down, with longer acquisition (R3)
    acq_len_i = 8'd60;
    do_conv(2'd1, 8'd4, 4'd4, 12'h3C7, 12'h3C7, "R7 power-down");
    chk(hi_seen == 0, "R7 strobe low", hi_seen, 0);
    cnt = 0;
    while (busy_o && cnt < 500) begin cnt++; @(negedge clk_i); end
    chk(cnt == 61, "R3 acquisition", cnt, 61);
    acq_len_i = 8'd0;

    // R8 LSB-first
    do_conv(2'd2, 8'd5, 4'd4, 12'h5A3, 12'h5A3, "R8 lsb-first");
    chk(falls == 1, "R8 strobe drop", falls, 1);

    // R9 short cycle, nominal and clamped counts
    do_conv(2'd3, 8'd4, 4'd4, 12'hBCD, 12'hB00, "R9 short 4");
    chk(falls == 1, "R9 strobe drop", falls, 1);
    do_conv(2'd3, 8'd4, 4'd0, 12'hBCD, 12'h800, "R9 short clamp low");
    do_conv(2'd3, 8'd4, 4'd15, 12'hBCD, 12'hBCC, "R9 short clamp high");

    // R12 configuration changed mid-transfer
    wait_ready();
    mode_i = 2'd0; clk_div_i = 8'd4; adc_data = 12'h6E1;
    start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
    repeat (20) @(negedge clk_i);
    mode_i = 2'd3; short_bits_i = 4'd2; clk_div_i = 8'd9;
    cnt = 0;
    while (!valid_o && cnt < 2000) begin cnt++; @(negedge clk_i); end
    chk(result_o == 12'h6E1, "R12 latched config", result_o, 12'h6E1);
    mode_i = 2'd0; clk_div_i = 8'd4;

    // R11 start while busy
    chk(overrun_o == 1'b0, "R11 clear before", overrun_o, 0);
    wait_ready();
    adc_data = 12'h0F0;
    start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
    repeat (30) @(negedge clk_i);
    start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
    chk(overrun_o == 1'b1, "R11 overrun set", overrun_o, 1);
    nv = 0;
    repeat (400) begin @(negedge clk_i); if (valid_o) nv++; end
    chk(nv == 1, "R11 ignored start", nv, 1);
    chk(overrun_o == 1'b1, "R11 sticky", overrun_o, 1);

    // R10 rate timer
    wait_ready();
    repeat (50) @(negedge clk_i);
    adc_data = 12'h321;
    rate_period_i = 16'd300; rate_en_i = 1'b1;
    nv = 0;
    repeat (1500) begin @(negedge clk_i); if (valid_o) nv++; end
    rate_en_i = 1'b0;
    chk(nv == 4, "R10 rate conversions", nv, 4);
    chk(result_o == 12'h321, "R10 rate result", result_o, 12'h321);

    repeat (300) @(negedge clk_i);
    fin = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule